// File: doc/BRIEF.md
# Hardwired Step-Counter Control Sequencer

This block is the control unit for a processor built around one shared internal bus. A step counter walks through timing slots T1 to T7. Combinational logic turns the current slot, the decoded opcode and the two condition flags into a bundle of control strobes. These strobes open register drivers onto the bus, load registers, select the ALU operation, and start memory reads and writes.

Every instruction begins with the same three-slot fetch. The block then runs the execute slots for one of sixteen fixed-length instructions. When it raises End, the counter goes back to T1 on the next edge. In any slot that waits for memory, the counter holds until the memory-function-complete input is high.

The datapath is outside this block. It supplies the four opcode bits taken from the top of its instruction register, together with the zero and negative flags. The step number is brought out so that the datapath, or a probe, can see which slot is active.

Top module: `hwctl_hardwired`

## Requirements
- R1: While reset is high and in the first cycle after it, the step number is 1 and the T1 fetch strobes are driven.
- R2: For every opcode, slot 1 drives pc_out, mar_in, mem_rd, sel_four, z_in and ALU add. Slot 2 drives z_out, pc_in, y_in, mdr_in_ext and wait_mfc. Slot 3 drives mdr_out and ir_in.
- R3: End returns the step number to 1 on the next edge. Otherwise a slot that is not stalled moves the step number up by one.
- R4: In a slot with wait_mfc high and mfc low, the step number and every strobe stay unchanged until mfc rises.
- R5: Opcode 0 is a register move, and slot 4 drives rs_out, rd_in and End. Opcode 1 is a load of the immediate, and slot 4 drives imm_out, rd_in and End.
- R6: Opcode 2 is a load through a register. Slot 4 drives rs_out, mar_in and mem_rd. Slot 5 drives mdr_in_ext and wait_mfc. Slot 6 drives mdr_out, rd_in and End.
- R7: Opcode 3 is a store. Slot 4 drives rd_out and mar_in. Slot 5 drives rs_out and mdr_in_int. Slot 6 drives mem_wr, wait_mfc and End, and holds until mfc is high.
- R8: Opcodes 4, 5, 6 and 7 are register-to-register add, subtract, AND and OR. Slot 4 drives rd_out and y_in. Slot 5 drives rs_out and z_in, with alu_op set to 0, 1, 2 or 3 respectively. Slot 6 drives z_out, rd_in and End.
- R9: Opcode 8 compares a register with the immediate. Slot 4 drives imm_out and y_in. Slot 5 drives rd_out, sets alu_op to 1 (subtract) and drives End. No slot drives rd_in.
- R10: Opcode 9 is an unconditional branch. Slot 4 drives imm_out, z_in and ALU add with sel_four low. Slot 5 drives z_out, pc_in and End.
- R11: Opcodes 10, 11 and 12 branch when zero is set, when zero is clear, and when negative is set. If the condition fails, End is raised at slot 4 and pc_in is never driven. If it holds, they behave as in R10.
- R12: Opcodes 13, 14 and 15 are increment, invert and shift-left. Slot 4 drives rd_out and z_in, with alu_op set to 4, 5 or 6. Slot 5 drives z_out, rd_in and End.
- R13: In any cycle, at most one of pc_out, z_out, mdr_out, imm_out, rd_out and rs_out is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | OPC_W | Opcode bits from the instruction register |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| mfc | input | 1 | Memory function complete |
| pc_out | output | 1 | Drive PC onto bus |
| pc_in | output | 1 | Load PC from bus |
| mar_in | output | 1 | Load memory address register |
| mem_rd | output | 1 | Start memory read |
| mem_wr | output | 1 | Start memory write |
| sel_four | output | 1 | ALU A input takes constant 4 (else Y) |
| alu_op | output | 3 | ALU function code |
| z_in | output | 1 | Load Z with ALU result |
| z_out | output | 1 | Drive Z onto bus |
| y_in | output | 1 | Load Y from bus |
| mdr_in_ext | output | 1 | Load MDR from external data bus |
| mdr_in_int | output | 1 | Load MDR from internal bus |
| mdr_out | output | 1 | Drive MDR onto bus |
| ir_in | output | 1 | Load instruction register |
| imm_out | output | 1 | Drive IR offset field onto bus |
| rd_out | output | 1 | Drive destination-field register onto bus |
| rs_out | output | 1 | Drive source-field register onto bus |
| rd_in | output | 1 | Load destination-field register |
| wait_mfc | output | 1 | Hold the step until mfc |
| end_step | output | 1 | Last slot of the instruction |
| step_num | output | STEP_W | Current slot number, 1 based |

## Verification
The bench builds the block with its default parameters: a four-bit opcode and seven slots. With these values all sixteen opcodes can be reached. Every conditional branch is run once with its condition true and once with it false. Each instruction is run with memory answering at once and again with two to three idle cycles on every wait slot, so the stall holds in the fetch, the load and the store slots are all covered.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_INC = 3'd4,
    ALU_INV = 3'd5,
    ALU_SHL = 3'd6
  } alu_op_e;

  localparam int OP_MOV = 0;
  localparam int OP_LDI = 1;
  localparam int OP_LDX = 2;
  localparam int OP_STR = 3;
  localparam int OP_ADD = 4;
  localparam int OP_SUB = 5;
  localparam int OP_AND = 6;
  localparam int OP_OR  = 7;
  localparam int OP_CMP = 8;
  localparam int OP_BRA = 9;
  localparam int OP_BRZ = 10;
  localparam int OP_BNZ = 11;
  localparam int OP_BRM = 12;
  localparam int OP_INC = 13;
  localparam int OP_INV = 14;
  localparam int OP_SHL = 15;

  typedef struct packed {
    logic    pc_out;
    logic    pc_in;
    logic    mar_in;
    logic    mem_rd;
    logic    mem_wr;
    logic    sel_four;
    alu_op_e alu;
    logic    z_in;
    logic    z_out;
    logic    y_in;
    logic    mdr_in_ext;
    logic    mdr_in_int;
    logic    mdr_out;
    logic    ir_in;
    logic    imm_out;
    logic    rd_out;
    logic    rs_out;
    logic    rd_in;
    logic    wait_mfc;
    logic    end_step;
  } ctl_t;

endpackage

// File: rtl/hwctl_step_ctr.sv
module hwctl_step_ctr #(
  parameter int NUM_STEPS = 7,
  parameter int STEP_W    = $clog2(NUM_STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 end_step,
  input  logic                 wait_mfc,
  input  logic                 mfc,
  output logic [STEP_W-1:0]    step,
  output logic [NUM_STEPS-1:0] t_hot
);

  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);
  localparam logic [STEP_W-1:0] LAST  = STEP_W'(NUM_STEPS);

  logic stall;
  assign stall = wait_mfc && !mfc;

  always_ff @(posedge clk) begin
    if (rst)                          step <= FIRST;
    else if (stall)                   step <= step;
    else if (end_step || step == LAST) step <= FIRST;
    else                              step <= step + FIRST;
  end

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_slot
    assign t_hot[k] = (step == STEP_W'(k + 1));
  end

  a_r3_end_to_first: assert property (@(posedge clk) disable iff (rst)
    (end_step && !stall) |=> (step == FIRST));

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (!end_step && !stall && step != LAST) |=> (step == STEP_W'($past(step) + 1)));

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(step));

endmodule

// File: rtl/hwctl_op_dec.sv
module hwctl_op_dec #(
  parameter int OPC_W   = 4,
  parameter int NUM_OPS = 1 << OPC_W
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [NUM_OPS-1:0] op_hot
);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    assign op_hot[i] = (opcode == OPC_W'(i));
  end

endmodule

// File: rtl/hwctl_strobes.sv
module hwctl_strobes
  import hwctl_pkg::*;
#(
  parameter int NUM_STEPS = 7,
  parameter int NUM_OPS   = 16
) (
  input  logic [NUM_STEPS-1:0] t_hot,
  input  logic [NUM_OPS-1:0]   op_hot,
  input  logic                 flag_z,
  input  logic                 flag_n,
  output ctl_t                 ctl
);

  logic t1, t2, t3, t4, t5, t6, t7;
  logic mov, ldi, ldx, st, rr, cmp, br_any, un, br_fail;

  assign t1 = t_hot[0];
  assign t2 = t_hot[1];
  assign t3 = t_hot[2];
  assign t4 = t_hot[3];
  assign t5 = t_hot[4];
  assign t6 = t_hot[5];
  assign t7 = t_hot[6];

  assign mov     = op_hot[OP_MOV];
  assign ldi     = op_hot[OP_LDI];
  assign ldx     = op_hot[OP_LDX];
  assign st      = op_hot[OP_STR];
  assign rr      = op_hot[OP_ADD] | op_hot[OP_SUB] | op_hot[OP_AND] | op_hot[OP_OR];
  assign cmp     = op_hot[OP_CMP];
  assign br_any  = op_hot[OP_BRA] | op_hot[OP_BRZ] | op_hot[OP_BNZ] | op_hot[OP_BRM];
  assign un      = op_hot[OP_INC] | op_hot[OP_INV] | op_hot[OP_SHL];
  assign br_fail = (op_hot[OP_BRZ] & !flag_z) | (op_hot[OP_BNZ] & flag_z) |
                   (op_hot[OP_BRM] & !flag_n);

  always_comb begin
    ctl            = '0;
    ctl.pc_out     = t1;
    ctl.sel_four   = t1;
    ctl.mar_in     = t1 | (t4 & (ldx | st));
    ctl.mem_rd     = t1 | (t4 & ldx);
    ctl.mem_wr     = t6 & st;
    ctl.z_in       = t1 | (t5 & rr) | (t4 & (br_any | un));
    ctl.pc_in      = t2 | (t5 & br_any);
    ctl.y_in       = t2 | (t4 & (rr | cmp));
    ctl.z_out      = t2 | (t6 & rr) | (t5 & (br_any | un));
    ctl.wait_mfc   = t2 | (t5 & ldx) | (t6 & st);
    ctl.mdr_in_ext = t2 | (t5 & ldx);
    ctl.mdr_in_int = t5 & st;
    ctl.mdr_out    = t3 | (t6 & ldx);
    ctl.ir_in      = t3;
    ctl.imm_out    = t4 & (ldi | cmp | br_any);
    ctl.rd_out     = (t4 & (rr | un | st)) | (t5 & cmp);
    ctl.rs_out     = (t4 & (mov | ldx)) | (t5 & (rr | st));
    ctl.rd_in      = (t4 & (mov | ldi)) | (t5 & un) | (t6 & (rr | ldx));
    ctl.end_step   = (t4 & (mov | ldi | br_fail)) | (t5 & (cmp | br_any | un)) |
                     (t6 & (ldx | st | rr)) | t7;

    ctl.alu = ALU_ADD;
    if (t5) begin
      if (op_hot[OP_SUB] | cmp) ctl.alu = ALU_SUB;
      else if (op_hot[OP_AND])  ctl.alu = ALU_AND;
      else if (op_hot[OP_OR])   ctl.alu = ALU_OR;
    end
    if (t4) begin
      if (op_hot[OP_INC])      ctl.alu = ALU_INC;
      else if (op_hot[OP_INV]) ctl.alu = ALU_INV;
      else if (op_hot[OP_SHL]) ctl.alu = ALU_SHL;
    end
  end

endmodule

// File: rtl/hwctl_hardwired.sv
module hwctl_hardwired
  import hwctl_pkg::*;
#(
  parameter int OPC_W     = 4,
  parameter int NUM_STEPS = 7,
  parameter int STEP_W    = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  ir_opcode,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              mfc,
  output logic              pc_out,
  output logic              pc_in,
  output logic              mar_in,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              sel_four,
  output logic [2:0]        alu_op,
  output logic              z_in,
  output logic              z_out,
  output logic              y_in,
  output logic              mdr_in_ext,
  output logic              mdr_in_int,
  output logic              mdr_out,
  output logic              ir_in,
  output logic              imm_out,
  output logic              rd_out,
  output logic              rs_out,
  output logic              rd_in,
  output logic              wait_mfc,
  output logic              end_step,
  output logic [STEP_W-1:0] step_num
);

  localparam int NUM_OPS = 1 << OPC_W;

  logic [NUM_STEPS-1:0] t_hot;
  logic [NUM_OPS-1:0]   op_hot;
  ctl_t                 ctl;

  hwctl_step_ctr #(.NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W)) u_ctr (
    .clk(clk), .rst(rst), .end_step(ctl.end_step), .wait_mfc(ctl.wait_mfc),
    .mfc(mfc), .step(step_num), .t_hot(t_hot)
  );

  hwctl_op_dec #(.OPC_W(OPC_W), .NUM_OPS(NUM_OPS)) u_dec (
    .opcode(ir_opcode), .op_hot(op_hot)
  );

  hwctl_strobes #(.NUM_STEPS(NUM_STEPS), .NUM_OPS(NUM_OPS)) u_stb (
    .t_hot(t_hot), .op_hot(op_hot), .flag_z(flag_z), .flag_n(flag_n), .ctl(ctl)
  );

  assign pc_out     = ctl.pc_out;
  assign pc_in      = ctl.pc_in;
  assign mar_in     = ctl.mar_in;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign sel_four   = ctl.sel_four;
  assign alu_op     = ctl.alu;
  assign z_in       = ctl.z_in;
  assign z_out      = ctl.z_out;
  assign y_in       = ctl.y_in;
  assign mdr_in_ext = ctl.mdr_in_ext;
  assign mdr_in_int = ctl.mdr_in_int;
  assign mdr_out    = ctl.mdr_out;
  assign ir_in      = ctl.ir_in;
  assign imm_out    = ctl.imm_out;
  assign rd_out     = ctl.rd_out;
  assign rs_out     = ctl.rs_out;
  assign rd_in      = ctl.rd_in;
  assign wait_mfc   = ctl.wait_mfc;
  assign end_step   = ctl.end_step;

  a_r13_one_bus_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_out, z_out, mdr_out, imm_out, rd_out, rs_out}));

  a_r2_fetch_first_slot: assert property (@(posedge clk) disable iff (rst)
    (step_num == STEP_W'(1)) |-> (pc_out && mar_in && mem_rd && z_in && !end_step));

  a_r7_write_held: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mfc) |=> mem_wr);

  a_r2_ir_load_follows_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_in) |-> $past(wait_mfc));

endmodule

// File: tb/hwctl_hardwired_tb.sv
module hwctl_hardwired_tb;

  localparam int STEP_W = 3;

  logic clk = 1'b0;
  logic rst;
  logic [3:0] ir_opcode;
  logic flag_z, flag_n, mfc;
  logic pc_out, pc_in, mar_in, mem_rd, mem_wr, sel_four;
  logic [2:0] alu_op;
  logic z_in, z_out, y_in, mdr_in_ext, mdr_in_int, mdr_out, ir_in;
  logic imm_out, rd_out, rs_out, rd_in, wait_mfc, end_step;
  logic [STEP_W-1:0] step_num;

  always #4 clk = ~clk;

  hwctl_hardwired u_dut (
    .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .flag_z(flag_z), .flag_n(flag_n),
    .mfc(mfc), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .sel_four(sel_four), .alu_op(alu_op), .z_in(z_in), .z_out(z_out),
    .y_in(y_in), .mdr_in_ext(mdr_in_ext), .mdr_in_int(mdr_in_int), .mdr_out(mdr_out),
    .ir_in(ir_in), .imm_out(imm_out), .rd_out(rd_out), .rs_out(rs_out), .rd_in(rd_in),
    .wait_mfc(wait_mfc), .end_step(end_step), .step_num(step_num)
  );

  typedef struct {
    logic [24:0] v;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  // vector layout: 19 strobes, alu_op[5:3], step[2:0]; end is bit 6, wait is bit 7
  function automatic logic [24:0] observed();
    return {pc_out, pc_in, mar_in, mem_rd, mem_wr, sel_four, z_in, z_out, y_in,
            mdr_in_ext, mdr_in_int, mdr_out, ir_in, imm_out, rd_out, rs_out, rd_in,
            wait_mfc, end_step, alu_op, step_num};
  endfunction

  function automatic logic [24:0] model(int opc, int s, bit z, bit n);
    bit po = 0, pi = 0, ma = 0, rd = 0, wr = 0, s4 = 0, zi = 0, zo = 0, yi = 0;
    bit me = 0, mi = 0, mo = 0, ii = 0, io = 0, dout = 0, sout = 0, din = 0, wt = 0, en = 0;
    logic [2:0] alu = 3'd0;
    bit cond;
    cond = (opc == 9) || (opc == 10 && z) || (opc == 11 && !z) || (opc == 12 && n);
    case (s)
      1: begin po = 1; ma = 1; rd = 1; s4 = 1; zi = 1; end
      2: begin zo = 1; pi = 1; yi = 1; wt = 1; me = 1; end
      3: begin mo = 1; ii = 1; end
      default: ;
    endcase
    if (s >= 4) begin
      case (opc)
        0: begin sout = 1; din = 1; en = 1; end
        1: begin io = 1; din = 1; en = 1; end
        2: case (s)
             4: begin sout = 1; ma = 1; rd = 1; end
             5: begin me = 1; wt = 1; end
             default: begin mo = 1; din = 1; en = 1; end
           endcase
        3: case (s)
             4: begin dout = 1; ma = 1; end
             5: begin sout = 1; mi = 1; end
             default: begin wr = 1; wt = 1; en = 1; end
           endcase
        4, 5, 6, 7: case (s)
             4: begin dout = 1; yi = 1; end
             5: begin sout = 1; zi = 1; alu = 3'(opc - 4); end
             default: begin zo = 1; din = 1; en = 1; end
           endcase
        8: if (s == 4) begin io = 1; yi = 1; end
           else begin dout = 1; alu = 3'd1; en = 1; end
        9, 10, 11, 12: if (s == 4) begin io = 1; zi = 1; en = !cond; end
           else begin zo = 1; pi = 1; en = 1; end
        default: if (s == 4) begin dout = 1; zi = 1; alu = 3'(opc - 9); end
           else begin zo = 1; din = 1; en = 1; end
      endcase
    end
    return {po, pi, ma, rd, wr, s4, zi, zo, yi, me, mi, mo, ii, io, dout, sout, din,
            wt, en, alu, 3'(s)};
  endfunction

  function automatic string op_tag(int opc);
    case (opc)
      0, 1:          return "R5";
      2:             return "R6";
      3:             return "R7";
      4, 5, 6, 7:    return "R8";
      8:             return "R9";
      9:             return "R10";
      10, 11, 12:    return "R11";
      default:       return "R12";
    endcase
  endfunction

  task automatic push(logic [24:0] v, string tag);
    item_t it;
    it.v = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Driver: runs one instruction cycle by cycle; each cycle's expectation goes to the queue
  task automatic run_op(int opc, bit z, bit n, int stall);
    int s = 1;
    int left = stall;
    logic [24:0] e;
    string tag;
    forever begin
      ir_opcode = 4'(opc);
      flag_z = z;
      flag_n = n;
      e = model(opc, s, z, n);
      tag = (s == 1) ? "R3" : (s <= 3) ? "R2" : op_tag(opc);
      if (e[7] && left > 0) begin
        mfc = 1'b0;
        left--;
        push(e, "R4");
        @(posedge clk); #1;
      end else begin
        mfc = 1'b1;
        push(e, tag);
        @(posedge clk); #1;
        if (e[6]) break;
        if (e[7]) left = stall;
        s++;
      end
    end
  endtask

  // Monitor: compares one queued expectation per cycle at the falling edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      logic [24:0] got;
      it = q.pop_front();
      got = observed();
      checks++;
      if (got !== it.v) begin
        fails++;
        $display("FAIL %s: got %b expected %b (step %0d)", it.tag, got, it.v, it.v[2:0]);
      end
      checks++;
      if ($countones({pc_out, z_out, mdr_out, imm_out, rd_out, rs_out}) > 1) begin
        fails++;
        $display("FAIL R13: bus drivers %0d expected at most 1",
                 $countones({pc_out, z_out, mdr_out, imm_out, rd_out, rs_out}));
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ir_opcode = 4'd7; flag_z = 1'b0; flag_n = 1'b0; mfc = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (observed() !== model(0, 1, 0, 0)) begin
      fails++;
      $display("FAIL R1: got %b expected %b", observed(), model(0, 1, 0, 0));
    end
    @(posedge clk); #1;
    rst = 1'b0;
    for (int opc = 0; opc < 16; opc++) run_op(opc, 1'b0, 1'b0, 0);
    for (int opc = 0; opc < 16; opc++) run_op(opc, 1'b1, 1'b1, 2);
    for (int opc = 10; opc < 13; opc++) begin
      run_op(opc, 1'b0, 1'b1, 0);
      run_op(opc, 1'b1, 1'b0, 1);
    end
    run_op(2, 1'b0, 1'b0, 3);
    run_op(3, 1'b0, 1'b0, 3);
    run_op(9, 1'b0, 1'b0, 0);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule